// File: doc/BRIEF.md
# Carry-Partitioned Packed Adder

This block is a 32-bit adder whose carry chain can be cut at any bit position. A boundary mask register holds one bit per position. When a packed addition is requested, each set mask bit stops the carry from reaching that bit, so that bit becomes the lowest bit of a new element. One adder can therefore perform several independent additions whose elements have different widths. Two packed 16-bit colour pixels with 5/6/5 fields are one example. An ordinary addition ignores the mask and carries across the whole word.

The mask is loaded through a single-cycle register-write port. An operation is presented on the operand inputs together with a valid strobe and a packed/normal select. The sum is formed combinationally from the operands and the stored mask. It is captured into the output register on each clock edge where the strobe is high. The output register keeps its value between operations.

Top module: `pa_packed_adder`

## Requirements
- R1: With `op_packed` low, the captured sum is `opnd_a + opnd_b` modulo 2^32, with carries crossing every bit whatever the mask holds.
- R2: With `op_packed` high, a set mask bit i (i from 1 to 31) stops the carry into bit i. Each run of bits from one boundary up to the bit below the next boundary, or up to bit 31, is added on its own.
- R3: Mask bit 0 has no effect. A packed add with only bit 0 of the mask set gives the same result as a normal add.
- R4: The carry out of the top bit of every element is dropped, so each element wraps modulo 2 to the power of its width. The carry out of bit 31 is also dropped.
- R5: With mask 0x08210820 (boundaries at bits 5, 11, 16, 21, 27), the six colour fields 4..0, 10..5, 15..11, 20..16, 26..21 and 31..27 are added independently. Adding 0x08210821 to 0xFFFFFFFF gives 0x00000000 packed and 0x08210820 normal.
- R6: Synchronous active-high reset clears the mask and the output register to zero, so a packed add behaves as a normal add until the mask is written.
- R7: When `mask_wr_en` is high, the mask takes `mask_wr_data` at the clock edge. An operation captured on that same edge still uses the previous mask.
- R8: `sum_q` is loaded only on edges where `op_valid` is high and holds its value otherwise.
- R9: With mask bits 31..1 all set, a packed add is 32 separate one-bit additions and gives `opnd_a ^ opnd_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mask_wr_en | input | 1 | Load strobe for the boundary mask |
| mask_wr_data | input | 32 | New boundary mask value |
| op_valid | input | 1 | Capture the sum on this edge |
| op_packed | input | 1 | 1 = packed add using the mask, 0 = normal add |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sum_q | output | 32 | Registered sum |

## Verification
The hardest case to reach is a carry that would ripple across a boundary. Only operands whose lower element overflows exactly at the cut show whether the carry was blocked. The stimulus table therefore pairs each mask with all-ones fields plus a one at each element's low bit, so that every element wraps at once. A reference model checks these results by adding each field separately. The other hard case is a mask write and a packed operation on the same edge. A directed test drives both strobes in one cycle and then repeats the operation, so that the old mask and then the new mask are seen at the output.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int DATA_W = 32;
    localparam int MSB    = DATA_W - 1;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        ADD_NORMAL = 1'b0,
        ADD_PACKED = 1'b1
    } add_mode_e;

    typedef struct packed {
        add_mode_e mode;
        word_t     a;
        word_t     b;
    } add_op_t;

    // Carry into a bit is cut only for packed mode at a marked boundary.
    function automatic logic carry_cut(input add_mode_e mode, input logic bnd);
        return (mode == ADD_PACKED) && bnd;
    endfunction

endpackage

// File: rtl/pa_bound_reg.sv
module pa_bound_reg
    import pa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_data,
    output word_t bound_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_q <= '0;
        end else if (wr_en) begin
            bound_q <= wr_data;
        end
    end

endmodule

// File: rtl/pa_seg_adder.sv
module pa_seg_adder
    import pa_pkg::*;
(
    input  add_op_t op,
    input  word_t   bound,
    output word_t   sum
);

    logic [MSB:1] carry;
    logic         unused_bound0;

    assign unused_bound0 = bound[0];

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic cin;
        logic half;

        if (i == 0) begin : g_lsb
            assign cin = 1'b0;
        end else begin : g_mid
            assign cin = carry[i] & ~carry_cut(op.mode, bound[i]);
        end

        assign half   = op.a[i] ^ op.b[i];
        assign sum[i] = half ^ cin;

        if (i < MSB) begin : g_cout
            assign carry[i+1] = (op.a[i] & op.b[i]) | (cin & half);
        end
    end

endmodule

// File: rtl/pa_result_reg.sv
module pa_result_reg
    import pa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t d,
    output word_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/pa_packed_adder.sv
module pa_packed_adder
    import pa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mask_wr_en,
    input  logic [31:0] mask_wr_data,
    input  logic        op_valid,
    input  logic        op_packed,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    output logic [31:0] sum_q
);

    word_t   mask_q;
    word_t   sum_d;
    add_op_t cur_op;

    always_comb begin
        cur_op.mode = op_packed ? ADD_PACKED : ADD_NORMAL;
        cur_op.a    = opnd_a;
        cur_op.b    = opnd_b;
    end

    pa_bound_reg u_bound (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_wr_en),
        .wr_data (mask_wr_data),
        .bound_q (mask_q)
    );

    pa_seg_adder u_add (
        .op    (cur_op),
        .bound (mask_q),
        .sum   (sum_d)
    );

    pa_result_reg u_res (
        .clk  (clk),
        .rst  (rst),
        .load (op_valid),
        .d    (sum_d),
        .q    (sum_q)
    );

endmodule

// File: rtl/pa_packed_adder_chk.sv
module pa_packed_adder_chk
    import pa_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mask_wr_en,
    input logic [31:0] mask_wr_data,
    input logic        op_valid,
    input logic        op_packed,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [31:0] sum_q,
    input logic [31:0] mask_q
);

    logic [31:0] full_sum;
    logic [31:0] bitwise_sum;
    assign full_sum    = opnd_a + opnd_b;
    assign bitwise_sum = opnd_a ^ opnd_b;

    p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sum_q == 32'd0 && mask_q == 32'd0));

    p_normal_add_r1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_packed) |=> (sum_q == $past(full_sum)));

    p_bit0_inert_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_packed && mask_q[31:1] == 31'd0) |=> (sum_q == $past(full_sum)));

    p_onebit_lanes_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_packed && (&mask_q[31:1])) |=> (sum_q == $past(bitwise_sum)));

    p_zero_operand_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opnd_a == 32'd0) |=> (sum_q == $past(opnd_b)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(sum_q));

    p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
        mask_wr_en |=> (mask_q == $past(mask_wr_data)));

endmodule

bind pa_packed_adder pa_packed_adder_chk u_chk (.*);

// File: tb/tb_pa_packed_adder.sv
module tb_pa_packed_adder;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // each entry: {mask, a, b, packed}
    localparam logic [96:0] VEC [NVEC] = '{
        {32'h08210820, 32'hFFFFFFFF, 32'h08210821, 1'b1},
        {32'h08210820, 32'h7BEF7BEF, 32'h18E318E3, 1'b1},
        {32'h08210820, 32'h12345678, 32'h9ABCDEF0, 1'b0},
        {32'h00010000, 32'h0000FFFF, 32'h00000001, 1'b1},
        {32'h01010100, 32'hFFFFFFFF, 32'h01010101, 1'b1},
        {32'h80000002, 32'hC3A5F00D, 32'h5A5AFFF3, 1'b1},
        {32'hFFFFFFFE, 32'hDEADBEEF, 32'h13579BDF, 1'b1},
        {32'h00000001, 32'hFFFFFFFF, 32'h00000001, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        mask_wr_en;
    logic [31:0] mask_wr_data;
    logic        op_valid;
    logic        op_packed;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [31:0] sum_q;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pa_packed_adder dut (
        .clk(clk), .rst(rst), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .op_valid(op_valid), .op_packed(op_packed), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .sum_q(sum_q)
    );

    // field-by-field reference model
    function automatic logic [31:0] ref_sum(input logic [31:0] a, input logic [31:0] b,
                                            input logic p, input logic [31:0] m);
        logic [63:0] res;
        logic [63:0] fm;
        logic [63:0] fa;
        logic [63:0] fb;
        int lo;
        res = '0;
        lo  = 0;
        for (int i = 1; i <= 32; i++) begin
            if (i == 32 || (p && m[i % 32])) begin
                fm  = (64'd1 << (i - lo)) - 64'd1;
                fa  = ({32'd0, a} >> lo) & fm;
                fb  = ({32'd0, b} >> lo) & fm;
                res = res | (((fa + fb) & fm) << lo);
                lo  = i;
            end
        end
        return res[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        total++;
        if (sum_q !== exp) begin
            bad++;
            $display("FAIL %s: sum_q=%08h expected=%08h", req, sum_q, exp);
        end
    endtask

    task automatic wr_mask(input logic [31:0] m);
        @(negedge clk);
        mask_wr_en   = 1'b1;
        mask_wr_data = m;
        @(negedge clk);
        mask_wr_en   = 1'b0;
    endtask

    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic p);
        @(negedge clk);
        op_valid  = 1'b1;
        op_packed = p;
        opnd_a    = a;
        opnd_b    = b;
        @(negedge clk);
        op_valid  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; mask_wr_en = 1'b0; mask_wr_data = '0;
        op_valid = 1'b0; op_packed = 1'b0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R6: reset value
        check("R6 reset sum", 32'h0);
        // R6: packed add before mask write behaves as normal add
        do_op(32'h0000FFFF, 32'h00000001, 1'b1);
        check("R6 unconfigured packed", 32'h00010000);

        // vector table (R1, R2, R3, R4, R5, R9)
        for (int k = 0; k < NVEC; k++) begin
            wr_mask(VEC[k][96:65]);
            do_op(VEC[k][64:33], VEC[k][32:1], VEC[k][0]);
            check($sformatf("R2 table vector %0d", k),
                  ref_sum(VEC[k][64:33], VEC[k][32:1], VEC[k][0], VEC[k][96:65]));
        end

        // R5: hand-computed colour pixels
        wr_mask(32'h08210820);
        do_op(32'hFFFFFFFF, 32'h08210821, 1'b1);
        check("R5 packed wrap all fields", 32'h00000000);
        do_op(32'hFFFFFFFF, 32'h08210821, 1'b0);
        check("R5 R1 normal ignores mask", 32'h08210820);

        // R4: element and top carry dropped
        wr_mask(32'h00010000);
        do_op(32'h0000FFFF, 32'h00000001, 1'b1);
        check("R4 element wrap", 32'h00000000);
        do_op(32'hFFFF0000, 32'h00010000, 1'b1);
        check("R4 top carry dropped", 32'h00000000);

        // R3: bit 0 only
        wr_mask(32'h00000001);
        do_op(32'h00000001, 32'h00000001, 1'b1);
        check("R3 bit0 inert", 32'h00000002);

        // R9: all boundaries
        wr_mask(32'hFFFFFFFF);
        do_op(32'hF0F0AAAA, 32'hFF00CCCC, 1'b1);
        check("R9 one-bit lanes", 32'h0FF06666);

        // R8: hold while op_valid low
        @(negedge clk);
        opnd_a = 32'h11111111; opnd_b = 32'h22222222; op_packed = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 hold without strobe", 32'h0FF06666);

        // R7: same-edge write uses old mask, next op uses new mask
        wr_mask(32'h00000000);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_data = 32'h00010000;
        op_valid = 1'b1; op_packed = 1'b1; opnd_a = 32'h0000FFFF; opnd_b = 32'h00000001;
        @(negedge clk);
        mask_wr_en = 1'b0; op_valid = 1'b0;
        check("R7 same edge old mask", 32'h00010000);
        do_op(32'h0000FFFF, 32'h00000001, 1'b1);
        check("R7 new mask applied", 32'h00000000);

        // R6: reset again clears mask and output
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R6 reset clears sum", 32'h0);
        do_op(32'h0000FFFF, 32'h00000001, 1'b1);
        check("R6 reset clears mask", 32'h00010000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule